// File: doc/BRIEF.md
# Serial Port Register Block

This block is the software-visible face of a FIFO-equipped asynchronous serial port. A simple word-indexed bus with separate write and read strobes reaches ten register slots: the line mode, the bit-rate divisor, the control word, the transmit byte, the status flags, the receive byte, the FIFO control word, the receive occupancy, the port pins and the line status. The block keeps five status flags. These are transmit-end, transmit-empty, break, receive-full and data-ready. Each flag clears only when a zero is written to its bit.

On the serializer side, the block hands each written transmit byte over with a one-cycle strobe. It drives the transmit and receive interrupt lines. It presents the mode, bit-rate, control and port values to the neighbouring logic. From the receive FIFO it takes the occupancy count, the head byte, and set pulses for receive-full, break and data-ready. It returns a pop strobe to the FIFO and a clear strobe when the FIFO is reset.

Several control-side effects are kept. Switching the transmitter off raises transmit-end. The transmit-interrupt enable bit appears directly on the transmit interrupt line. Reading the status word while the transmitter is enabled re-arms both transmit flags once the value has been returned.

Top module: `sercfg_regs`

## Requirements
- R1: After reset, the registers read as follows: mode 0x00, bit-rate 0xFF, control 0x20, port 0x00, FIFO control 0x0000, status 0x0060. Both interrupt outputs are low.
- R2: `bus_addr` is a word index. The slots are: 0 mode, 1 bit-rate, 2 control, 3 transmit byte, 4 status, 5 receive byte, 6 FIFO control, 7 receive count, 8 port, 9 line status. Read data is registered and appears on `bus_rdata` the cycle after the read strobe. A read and a write never share a cycle.
- R3: Writes are masked. Mode keeps bits under 0x7B, control under 0xFA and port under 0xF3. Bit-rate keeps all 8 bits and FIFO control keeps all 16 bits.
- R4: The status word carries transmit-end at bit 6, transmit-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0. All other bits read 0. A status write clears each flag whose bit is 0 and leaves unchanged each flag whose bit is 1.
- R5: A status read while control bit 5 is 1 returns the flags as they stood. From the next cycle, transmit-empty and transmit-end are both 1.
- R6: A control write with bit 5 at 0 sets transmit-end.
- R7: `tx_irq` equals control bit 7 from the cycle after each control write.
- R8: A write to slot 3 raises `tx_strobe` for exactly one cycle, with `tx_byte` equal to the low 8 data bits. The same write clears transmit-empty.
- R9: `rx_irq` rises the cycle after a receive-full set pulse arrives while control bit 6 is 1. It falls after a control write with bit 6 at 0, or after a status write with bit 1 or bit 0 at 0. Without a set pulse it does not rise, even if bit 6 is 1.
- R10: A set pulse on `rx_trig_set`, `brk_set` or `dr_set` wins over a zero-write clear of the same flag in the same cycle.
- R11: Slot 7 reads the `rx_count` input. Slot 9 and slot 3 read 0.
- R12: A read of slots 10 to 15 returns 0 and raises `rd_err` for one cycle. A mapped read leaves `rd_err` low.
- R13: `rx_trig_sel` presents FIFO-control bits 7:6. A FIFO-control write with bit 1 at 1 raises `fifo_clr` for one cycle.
- R14: A read of slot 5 with `rx_count` above 0 asserts `rx_pop` in the read cycle and returns `rx_head`. With `rx_count` at 0 it returns 0 and `rx_pop` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| rd_err | output | 1 | One-cycle pulse after an unmapped read |
| rx_count | input | 5 | Receive FIFO occupancy |
| rx_head | input | 8 | Byte at the FIFO head |
| rx_trig_set | input | 1 | Receive-full set pulse from the FIFO |
| brk_set | input | 1 | Break set pulse |
| dr_set | input | 1 | Data-ready set pulse |
| rx_pop | output | 1 | Pop strobe to the FIFO |
| fifo_clr | output | 1 | FIFO clear pulse |
| rx_trig_sel | output | 2 | Trigger-level code for the FIFO |
| tx_strobe | output | 1 | Transmit byte valid, one cycle |
| tx_byte | output | 8 | Transmit byte |
| ser_mode | output | 8 | Mode register value |
| ser_brate | output | 8 | Bit-rate register value |
| ser_ctrl | output | 8 | Control register value |
| ser_port | output | 8 | Port register value |
| tx_irq | output | 1 | Transmit interrupt line |
| rx_irq | output | 1 | Receive interrupt line |

## Verification
The hardest situation to reach from the ports is a zero-write clear that lands in the same cycle as a set pulse for the same flag. The bench reaches it by driving the status write and the FIFO set pulses on one falling edge, so that the same rising edge sees both. A second delicate point is the read-then-re-arm order of the status word. The bench first disables the transmitter and drains the flags. It then re-enables the transmitter and reads status twice, so that the first read must still show the old flags and the second must show them re-armed.

// File: rtl/sercfg_pkg.sv
// Package: shared constants for the serial register block.
// Assumes word-indexed slots; flag vector order is fixed below.
package sercfg_pkg;
    localparam int NSLOT   = 10;
    localparam int AW      = 4;
    localparam int NFLAG   = 5;

    typedef enum logic [AW-1:0] {
        SL_MODE  = 4'd0,
        SL_BRATE = 4'd1,
        SL_CTRL  = 4'd2,
        SL_TXB   = 4'd3,
        SL_STAT  = 4'd4,
        SL_RXB   = 4'd5,
        SL_FCTL  = 4'd6,
        SL_RCNT  = 4'd7,
        SL_PORT  = 4'd8,
        SL_LSTAT = 4'd9
    } slot_e;

    // Flag vector positions
    localparam int FL_DR   = 0;
    localparam int FL_RDF  = 1;
    localparam int FL_BRK  = 2;
    localparam int FL_TDE  = 3;
    localparam int FL_TEND = 4;

    // Status word bit positions
    localparam int SB_DR   = 0;
    localparam int SB_RDF  = 1;
    localparam int SB_BRK  = 4;
    localparam int SB_TDE  = 5;
    localparam int SB_TEND = 6;

    // Control bits with side effects
    localparam int CB_TXEN = 5;
    localparam int CB_RIE  = 6;
    localparam int CB_TIE  = 7;

    localparam logic [7:0] MODE_MASK = 8'h7B;
    localparam logic [7:0] CTRL_MASK = 8'hFA;
    localparam logic [7:0] PORT_MASK = 8'hF3;
endpackage

// File: rtl/sercfg_decode.sv
// Module: slot decoder. Turns the word index and strobes into
// one-hot write/read selects and flags reads outside the map.
// Assumes at most one strobe per cycle.
module sercfg_decode
    import sercfg_pkg::*;
#(
    parameter int SLOTS = NSLOT
) (
    input  logic [AW-1:0]    addr,
    input  logic             wr,
    input  logic             rd,
    output logic [SLOTS-1:0] wr_sel,
    output logic [SLOTS-1:0] rd_sel,
    output logic             rd_unmapped
);
    // one select line per mapped slot
    for (genvar i = 0; i < SLOTS; i++) begin : g_sel
        assign wr_sel[i] = wr && (addr == AW'(i));
        assign rd_sel[i] = rd && (addr == AW'(i));
    end

    // read outside the mapped range
    assign rd_unmapped = rd && (int'(addr) >= SLOTS);
endmodule

// File: rtl/sercfg_cfg.sv
// Module: configuration registers (mode, bit-rate, control, port,
// FIFO control) plus the transmit byte handoff and FIFO clear pulse.
// Assumes selects are one-hot and come from sercfg_decode.
module sercfg_cfg
    import sercfg_pkg::*;
#(
    parameter int         DW        = 16,
    parameter int         BW        = 8,
    parameter logic [7:0] BRATE_RST = 8'hFF,
    parameter logic [7:0] CTRL_RST  = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NSLOT-1:0] wr_sel,
    input  logic [DW-1:0] wdata,
    output logic [BW-1:0] mode_q,
    output logic [BW-1:0] brate_q,
    output logic [BW-1:0] ctrl_q,
    output logic [BW-1:0] port_q,
    output logic [DW-1:0] fctl_q,
    output logic [BW-1:0] tx_byte,
    output logic          tx_strobe,
    output logic          fifo_clr
);
    // masked configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            brate_q <= BRATE_RST;
            ctrl_q  <= CTRL_RST;
            port_q  <= '0;
            fctl_q  <= '0;
        end else begin
            if (wr_sel[SL_MODE])  mode_q  <= wdata[BW-1:0] & MODE_MASK;
            if (wr_sel[SL_BRATE]) brate_q <= wdata[BW-1:0];
            if (wr_sel[SL_CTRL])  ctrl_q  <= wdata[BW-1:0] & CTRL_MASK;
            if (wr_sel[SL_PORT])  port_q  <= wdata[BW-1:0] & PORT_MASK;
            if (wr_sel[SL_FCTL])  fctl_q  <= wdata;
        end
    end

    // transmit byte capture and one-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte   <= '0;
            tx_strobe <= 1'b0;
            fifo_clr  <= 1'b0;
        end else begin
            tx_strobe <= wr_sel[SL_TXB];
            fifo_clr  <= wr_sel[SL_FCTL] && wdata[1];
            if (wr_sel[SL_TXB]) tx_byte <= wdata[BW-1:0];
        end
    end
endmodule

// File: rtl/sercfg_status.sv
// Module: five status flags with write-zero-to-clear semantics,
// control-write side effects, read re-arm, and the receive interrupt.
// Assumes set pulses are one cycle wide; a set beats a clear.
module sercfg_status
    import sercfg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] wr_sel,
    input  logic [NSLOT-1:0] rd_sel,
    input  logic [DW-1:0]    wdata,
    input  logic             tx_en,
    input  logic             rie,
    input  logic             rx_trig_set,
    input  logic             brk_set,
    input  logic             dr_set,
    output logic [NFLAG-1:0] flag_q,
    output logic             rx_irq
);
    logic st_wr, ct_wr, rearm;
    logic irq_set, irq_clr;
    logic [NFLAG-1:0] flag_d;

    assign st_wr   = wr_sel[SL_STAT];
    assign ct_wr   = wr_sel[SL_CTRL];
    assign rearm   = rd_sel[SL_STAT] && tx_en;
    assign irq_set = rx_trig_set && rie;
    assign irq_clr = (ct_wr && !wdata[CB_RIE]) ||
                     (st_wr && (!wdata[SB_RDF] || !wdata[SB_DR]));

    // next-state for each flag: clear first, then sets override
    always_comb begin
        flag_d = flag_q;
        if (st_wr) begin
            if (!wdata[SB_TEND]) flag_d[FL_TEND] = 1'b0;
            if (!wdata[SB_TDE])  flag_d[FL_TDE]  = 1'b0;
            if (!wdata[SB_BRK])  flag_d[FL_BRK]  = 1'b0;
            if (!wdata[SB_RDF])  flag_d[FL_RDF]  = 1'b0;
            if (!wdata[SB_DR])   flag_d[FL_DR]   = 1'b0;
        end
        if (wr_sel[SL_TXB])            flag_d[FL_TDE]  = 1'b0;
        if (ct_wr && !wdata[CB_TXEN])  flag_d[FL_TEND] = 1'b1;
        if (rearm) begin
            flag_d[FL_TEND] = 1'b1;
            flag_d[FL_TDE]  = 1'b1;
        end
        if (rx_trig_set) flag_d[FL_RDF] = 1'b1;
        if (brk_set)     flag_d[FL_BRK] = 1'b1;
        if (dr_set)      flag_d[FL_DR]  = 1'b1;
    end

    // flag register
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= NFLAG'((1 << FL_TEND) | (1 << FL_TDE));
        else        flag_q <= flag_d;
    end

    // receive interrupt: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_irq <= 1'b0;
        else if (irq_set) rx_irq <= 1'b1;
        else if (irq_clr) rx_irq <= 1'b0;
    end
endmodule

// File: rtl/sercfg_regs.sv
// Module: top of the serial register block. Ties the decoder,
// configuration registers and status flags together and forms the
// registered read path. Assumes read and write never share a cycle.
module sercfg_regs
    import sercfg_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic          rd_err,
    input  logic [CW-1:0] rx_count,
    input  logic [BW-1:0] rx_head,
    input  logic          rx_trig_set,
    input  logic          brk_set,
    input  logic          dr_set,
    output logic          rx_pop,
    output logic          fifo_clr,
    output logic [1:0]    rx_trig_sel,
    output logic          tx_strobe,
    output logic [BW-1:0] tx_byte,
    output logic [BW-1:0] ser_mode,
    output logic [BW-1:0] ser_brate,
    output logic [BW-1:0] ser_ctrl,
    output logic [BW-1:0] ser_port,
    output logic          tx_irq,
    output logic          rx_irq
);
    localparam int PADB = DW - BW;
    localparam int PADC = DW - CW;

    logic [NSLOT-1:0] wr_sel, rd_sel;
    logic             rd_unmapped;
    logic [DW-1:0]    fctl_q;
    logic [NFLAG-1:0] flag_q;
    logic [DW-1:0]    rd_mux;
    logic [DW-1:0]    stat_word;

    sercfg_decode #(.SLOTS(NSLOT)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wr_sel(wr_sel), .rd_sel(rd_sel), .rd_unmapped(rd_unmapped)
    );

    sercfg_cfg #(.DW(DW), .BW(BW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(bus_wdata),
        .mode_q(ser_mode), .brate_q(ser_brate), .ctrl_q(ser_ctrl),
        .port_q(ser_port), .fctl_q(fctl_q), .tx_byte(tx_byte),
        .tx_strobe(tx_strobe), .fifo_clr(fifo_clr)
    );

    sercfg_status #(.DW(DW)) u_st (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .rd_sel(rd_sel),
        .wdata(bus_wdata), .tx_en(ser_ctrl[CB_TXEN]), .rie(ser_ctrl[CB_RIE]),
        .rx_trig_set(rx_trig_set), .brk_set(brk_set), .dr_set(dr_set),
        .flag_q(flag_q), .rx_irq(rx_irq)
    );

    assign tx_irq      = ser_ctrl[CB_TIE];
    assign rx_trig_sel = fctl_q[7:6];
    assign rx_pop      = rd_sel[SL_RXB] && (rx_count != '0);

    // pack flags into the status word layout
    always_comb begin
        stat_word          = '0;
        stat_word[SB_TEND] = flag_q[FL_TEND];
        stat_word[SB_TDE]  = flag_q[FL_TDE];
        stat_word[SB_BRK]  = flag_q[FL_BRK];
        stat_word[SB_RDF]  = flag_q[FL_RDF];
        stat_word[SB_DR]   = flag_q[FL_DR];
    end

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            SL_MODE:  rd_mux = {{PADB{1'b0}}, ser_mode};
            SL_BRATE: rd_mux = {{PADB{1'b0}}, ser_brate};
            SL_CTRL:  rd_mux = {{PADB{1'b0}}, ser_ctrl};
            SL_STAT:  rd_mux = stat_word;
            SL_RXB:   rd_mux = rx_pop ? {{PADB{1'b0}}, rx_head} : '0;
            SL_FCTL:  rd_mux = fctl_q;
            SL_RCNT:  rd_mux = {{PADC{1'b0}}, rx_count};
            SL_PORT:  rd_mux = {{PADB{1'b0}}, ser_port};
            default:  rd_mux = '0;
        endcase
    end

    // registered read data and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            rd_err    <= 1'b0;
        end else begin
            rd_err <= rd_unmapped;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/sercfg_regs_chk.sv
// Module: property checker for sercfg_regs, attached by bind.
// Assumes the bus rule that read and write never share a cycle.
module sercfg_regs_chk
    import sercfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [15:0]      bus_wdata,
    input logic             tx_irq,
    input logic             rx_irq,
    input logic             tx_strobe,
    input logic [7:0]       tx_byte,
    input logic             rd_err,
    input logic             rx_trig_set,
    input logic [7:0]       ser_ctrl,
    input logic [NFLAG-1:0] flag_q
);
    p_txirq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SL_CTRL) |=> (tx_irq == $past(bus_wdata[7])));

    p_tx_handoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SL_TXB) |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));

    p_tx_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == SL_TXB) |=> !tx_strobe);

    p_rxirq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SL_CTRL && !bus_wdata[6] && !rx_trig_set) |=> !rx_irq);

    p_rdf_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_trig_set |=> flag_q[FL_RDF]);

    p_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == SL_STAT && ser_ctrl[5]) |=> (flag_q[FL_TEND] && flag_q[FL_TDE]));

    p_err_raise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_addr) >= NSLOT) |=> rd_err);

    p_err_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rd_err);
endmodule

bind sercfg_regs sercfg_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .rd_err(rd_err),
    .rx_trig_set(rx_trig_set), .ser_ctrl(ser_ctrl), .flag_q(flag_q)
);

// File: tb/sercfg_regs_tb.sv
// Bench: table-driven register write/readback, then directed tests.
module sercfg_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        rd_err;
    logic [4:0]  rx_count = '0;
    logic [7:0]  rx_head = '0;
    logic        rx_trig_set = 1'b0, brk_set = 1'b0, dr_set = 1'b0;
    logic        rx_pop, fifo_clr, tx_strobe, tx_irq, rx_irq;
    logic [1:0]  rx_trig_sel;
    logic [7:0]  tx_byte, ser_mode, ser_brate, ser_ctrl, ser_port;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    sercfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rd_err(rd_err), .rx_count(rx_count), .rx_head(rx_head),
        .rx_trig_set(rx_trig_set), .brk_set(brk_set), .dr_set(dr_set),
        .rx_pop(rx_pop), .fifo_clr(fifo_clr), .rx_trig_sel(rx_trig_sel),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .ser_mode(ser_mode),
        .ser_brate(ser_brate), .ser_ctrl(ser_ctrl), .ser_port(ser_port),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    // {slot, write data, expected readback}
    localparam logic [35:0] VEC [0:6] = '{
        {4'd0, 16'h00FF, 16'h007B},
        {4'd0, 16'h0084, 16'h0000},
        {4'd1, 16'h005A, 16'h005A},
        {4'd2, 16'h00FF, 16'h00FA},
        {4'd2, 16'h0005, 16'h0000},
        {4'd8, 16'h00FF, 16'h00F3},
        {4'd6, 16'h1234, 16'h1234}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input bit t, input bit b, input bit r);
        @(negedge clk);
        rx_trig_set = t; brk_set = b; dr_set = r;
        @(negedge clk);
        rx_trig_set = 1'b0; brk_set = 1'b0; dr_set = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {14'd0, tx_irq, rx_irq}, 16'h0);
        rd(4'd0, rv); check("R1 mode", rv, 16'h0000);
        rd(4'd1, rv); check("R1 brate", rv, 16'h00FF);
        rd(4'd2, rv); check("R1 ctrl", rv, 16'h0020);
        rd(4'd8, rv); check("R1 port", rv, 16'h0000);
        rd(4'd6, rv); check("R1 fctl", rv, 16'h0000);
        rd(4'd4, rv); check("R1 status", rv, 16'h0060);

        // R2 R3 table of masked write/readback
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][35:32], VEC[i][31:16]);
            rd(VEC[i][35:32], rv);
            check($sformatf("R3 R2 vec%0d", i), rv, VEC[i][15:0]);
        end

        // R4 clear all flags (control is 0: no re-arm)
        wr(4'd4, 16'h0000);
        rd(4'd4, rv); check("R4 all clear", rv, 16'h0000);
        pulse(1, 1, 1);
        rd(4'd4, rv); check("R4 sets", rv, 16'h0013);
        wr(4'd4, 16'h00FD);
        rd(4'd4, rv); check("R4 clear rdf only", rv, 16'h0011);
        wr(4'd4, 16'h00FF);
        rd(4'd4, rv); check("R4 ones keep", rv, 16'h0011);

        // R6 transmitter off sets transmit-end
        wr(4'd2, 16'h0000);
        rd(4'd4, rv); check("R6 tend", rv, 16'h0051);

        // R5 re-arm after read
        wr(4'd4, 16'h0000);
        wr(4'd2, 16'h0020);
        rd(4'd4, rv); check("R5 old value", rv, 16'h0000);
        rd(4'd4, rv); check("R5 rearmed", rv, 16'h0060);

        // R8 transmit handoff
        wr(4'd3, 16'h01A5);
        check("R8 strobe", {15'd0, tx_strobe}, 16'h1);
        check("R8 byte", {8'd0, tx_byte}, 16'h00A5);
        @(negedge clk);
        check("R8 one cycle", {15'd0, tx_strobe}, 16'h0);
        rd(4'd4, rv); check("R8 tde cleared", rv, 16'h0040);

        // R9 receive interrupt
        wr(4'd2, 16'h0060);
        check("R9 no pulse no irq", {15'd0, rx_irq}, 16'h0);
        pulse(1, 0, 0);
        check("R9 rise", {15'd0, rx_irq}, 16'h1);
        wr(4'd4, 16'h00FE);
        check("R9 status clr", {15'd0, rx_irq}, 16'h0);
        pulse(1, 0, 0);
        wr(4'd2, 16'h0020);
        check("R9 ctrl clr", {15'd0, rx_irq}, 16'h0);
        pulse(1, 0, 0);
        check("R9 disabled", {15'd0, rx_irq}, 16'h0);

        // R10 set wins over same-cycle clear (transmitter off: no re-arm)
        wr(4'd2, 16'h0000);
        wr(4'd4, 16'h0000);
        @(negedge clk);
        bus_addr = 4'd4; bus_wdata = 16'h0000; bus_wr = 1'b1;
        rx_trig_set = 1'b1; brk_set = 1'b1; dr_set = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_trig_set = 1'b0; brk_set = 1'b0; dr_set = 1'b0;
        rd(4'd4, rv); check("R10 set wins", rv, 16'h0013);

        // R7 transmit interrupt follows control bit 7
        wr(4'd2, 16'h0080);
        check("R7 tx_irq high", {15'd0, tx_irq}, 16'h1);
        wr(4'd2, 16'h0000);
        check("R7 tx_irq low", {15'd0, tx_irq}, 16'h0);

        // R11 count, line status, transmit slot
        rx_count = 5'd9;
        rd(4'd7, rv); check("R11 count", rv, 16'h0009);
        rd(4'd9, rv); check("R11 lstat", rv, 16'h0000);
        rd(4'd3, rv); check("R11 txb read", rv, 16'h0000);

        // R12 unmapped read
        rd(4'd12, rv);
        check("R12 data", rv, 16'h0000);
        check("R12 err", {15'd0, rd_err}, 16'h1);
        @(negedge clk);
        check("R12 err one cycle", {15'd0, rd_err}, 16'h0);
        rd(4'd1, rv);
        check("R12 mapped no err", {15'd0, rd_err}, 16'h0);

        // R13 FIFO control
        wr(4'd6, 16'h00C2);
        check("R13 clr pulse", {15'd0, fifo_clr}, 16'h1);
        check("R13 trig sel", {14'd0, rx_trig_sel}, 16'h3);
        @(negedge clk);
        check("R13 clr one cycle", {15'd0, fifo_clr}, 16'h0);
        wr(4'd6, 16'h0040);
        check("R13 no clr", {15'd0, fifo_clr}, 16'h0);

        // R14 receive byte read
        rx_count = 5'd3; rx_head = 8'h3C;
        @(negedge clk);
        bus_addr = 4'd5; bus_rd = 1'b1;
        #1 check("R14 pop", {15'd0, rx_pop}, 16'h1);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R14 data", bus_rdata, 16'h003C);
        rx_count = 5'd0;
        @(negedge clk);
        bus_addr = 4'd5; bus_rd = 1'b1;
        #1 check("R14 empty no pop", {15'd0, rx_pop}, 16'h0);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R14 empty data", bus_rdata, 16'h0000);

        finish_run();
    end
endmodule